// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a memory-mapped watchdog built around a 32-bit down-counter clocked by the core clock. Software reaches it through a plain register bus with an address, a write strobe, write data and combinational read data. To arm the watchdog, software sets a load value and then turns on the enable bit. From then on it must service the timer by writing the clear register before the count runs out. If the counter reaches zero once, the block raises an interrupt and starts counting again from the load value. If it reaches zero a second time while that interrupt is still pending, and reset is enabled, the block drives a reset pulse of fixed length.

Every register write except a write to the lock register is discarded unless the block is unlocked. Writing the 32-bit key to the lock register unlocks it. Writing any other value to the lock register locks it again. Reads work in both states. Once the reset pulse has fired, the block does not fire it again until the block itself is reset.

Top module: `wdg_keyed_timer`

## Requirements
- R1: After reset the block is locked, the enable and reset-enable bits are 0, no interrupt is pending, both outputs are low, and the load and count registers both read the parameter LOAD_INIT (all ones by default).
- R2: A write of 0x1ACCE551 to offset 0xC00 unlocks the block. A write of any other value to that offset locks it. The register at 0xC00 reads 1 while locked and 0 while unlocked.
- R3: While locked, writes to load (0x000), control (0x008) and clear (0x00C) have no effect. Reads of all registers still return their live values.
- R4: With control bit 0 set, the count register (0x004) falls by exactly one per clock cycle. Control bit 1 is reset-enable, and the control register reads back both bits at positions 0 and 1.
- R5: When an enabled counter at zero is clocked, the interrupt-pending flag is set, irq_o goes high, status (0x014) reads 1, and the counter reloads from the load register. A full period therefore lasts load+1 cycles.
- R6: Writing a value with bit 0 set to 0x00C clears the pending interrupt and reloads the counter from the load register. If this write lands in the same cycle as an expiry, the clear wins.
- R7: An expiry that occurs while the interrupt is still pending and reset-enable is set drives wdt_rst_o high for exactly RST_CYCLES cycles, starting on the next cycle. If reset-enable is clear, a second expiry produces no pulse.
- R8: After one reset pulse, no further pulse is produced until rst_n is applied. After rst_n, a pulse can be produced again.
- R9: Clearing control bit 0 freezes the count. Setting it again from 0 restarts the count at the load value.
- R10: The load register accepts the full 32-bit value 0xFFFFFFFF. The count register is read-only, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt pending |
| wdt_rst_o | output | 1 | Reset pulse |

## Verification
The hardest case to reach is the second expiry. It needs the interrupt to stay pending for a full period with reset-enable set, which happens only after a sequence of keyed writes, and after that the pulse must stay single-shot until the block is reset. The stimulus uses a six-cycle load, so both expiries fall within a few dozen cycles. It then keeps running well past the pulse to confirm that nothing fires again, and applies rst_n to show that the block can fire once more. A periodic clear sequence also drives clears close to expiry cycles, and a reference model that is compared on every clock checks the same-cycle priority.

// File: rtl/wdg_pkg.sv
// Package: register offsets and the unlock key shared by the watchdog modules.
// Assumes byte offsets on a 12-bit address bus and a 32-bit key.
package wdg_pkg;
    localparam logic [11:0] OFF_LOAD  = 12'h000;
    localparam logic [11:0] OFF_COUNT = 12'h004;
    localparam logic [11:0] OFF_CTRL  = 12'h008;
    localparam logic [11:0] OFF_CLR   = 12'h00C;
    localparam logic [11:0] OFF_STAT  = 12'h014;
    localparam logic [11:0] OFF_LOCK  = 12'hC00;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_RST_BIT = 1;
endpackage

// File: rtl/wdg_keylock.sv
// Keyed write lock. A write to the lock offset unlocks when the data equals
// KEY and locks otherwise. Comes out of reset locked.
// Assumes the caller decodes the lock offset into lk_wr_i.
module wdg_keylock #(
    parameter int          W   = 32,
    parameter logic [W-1:0] KEY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lk_wr_i,
    input  logic [W-1:0] lk_data_i,
    output logic         unlocked_o
);
    logic unl_q;

    // Track the lock state: only a lock-offset write can change it.
    always_ff @(posedge clk) begin
        if (!rst_n)       unl_q <= 1'b0;
        else if (lk_wr_i) unl_q <= (lk_data_i == KEY);
    end

    assign unlocked_o = unl_q;

    AST_STAY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_wr_i && !unl_q) |=> !unl_q); // R2
endmodule

// File: rtl/wdg_down_counter.sv
// Down-counter with expiry detection. A reload request wins over everything
// else. When enabled, the counter reloads when it passes zero. The first
// expiry sets the pending flag. An expiry while the flag is pending requests
// a reset, provided rst_en_i is set.
// Assumes reload_i is asserted whenever clr_i is.
module wdg_down_counter #(
    parameter int           W    = 32,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         rst_en_i,
    input  logic         reload_i,
    input  logic         clr_i,
    input  logic [W-1:0] load_i,
    output logic [W-1:0] count_o,
    output logic         irq_o,
    output logic         fire_o
);
    logic [W-1:0] cnt_q;
    logic         irq_q;
    logic         expire;

    assign expire = en_i && (cnt_q == '0) && !reload_i;

    // Count down, reloading on request or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= INIT;
        else if (reload_i) cnt_q <= load_i;
        else if (en_i)     cnt_q <= (cnt_q == '0) ? load_i : cnt_q - 1'b1;
    end

    // Track the pending interrupt: a clear beats a new expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_q <= 1'b0;
        else if (clr_i)  irq_q <= 1'b0;
        else if (expire) irq_q <= 1'b1;
    end

    assign count_o = cnt_q;
    assign irq_o   = irq_q;
    assign fire_o  = expire && irq_q && rst_en_i;

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !reload_i) |=> $stable(cnt_q)); // R9
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !reload_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
    AST_EXPIRY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == $past(load_i))); // R5
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !clr_i) |=> irq_q); // R5
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !irq_q); // R6
endmodule

// File: rtl/wdg_rst_pulse.sv
// Single-shot reset pulse generator. The first fire request starts a pulse of
// CYC cycles on the next cycle. Later requests are ignored until rst_n.
// Assumes CYC >= 1.
module wdg_rst_pulse #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int LW = $clog2(CYC + 1);

    logic [LW-1:0] left_q;
    logic          fired_q;

    // Load the pulse length once, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            fired_q <= 1'b0;
        end else if (fire_i && !fired_q) begin
            left_q  <= LW'(CYC);
            fired_q <= 1'b1;
        end else if (left_q != '0) begin
            left_q  <= left_q - 1'b1;
        end
    end

    assign pulse_o = (left_q != '0);

    AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fired_q |=> !$rose(pulse_o)); // R8
    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !fired_q) |=> pulse_o); // R7
endmodule

// File: rtl/wdg_keyed_timer.sv
// Top of the keyed two-stage watchdog: register decode, load and control
// registers, read mux, and the lock, counter and pulse submodules.
// Assumes single-cycle writes and combinational reads with no handshake.
module wdg_keyed_timer #(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 12,
    parameter int                RST_CYCLES = 4,
    parameter logic [DATA_W-1:0] LOAD_INIT  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              wdt_rst_o
);
    import wdg_pkg::*;

    localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFF_LOAD);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFF_CLR);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(OFF_LOCK);

    logic              unlocked;
    logic              wr_ok;
    logic              lk_wr;
    logic [DATA_W-1:0] load_q;
    logic              en_q;
    logic              rsten_q;
    logic              restart;
    logic              clr;
    logic [DATA_W-1:0] count;
    logic              irq;
    logic              fire;

    assign lk_wr   = bus_we && (bus_addr == A_LOCK);
    assign wr_ok   = bus_we && unlocked;
    assign restart = wr_ok && (bus_addr == A_CTRL) && bus_wdata[CTRL_EN_BIT] && !en_q;
    assign clr     = wr_ok && (bus_addr == A_CLR) && bus_wdata[0];

    wdg_keylock #(.W(DATA_W), .KEY(DATA_W'(UNLOCK_KEY))) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_wr_i    (lk_wr),
        .lk_data_i  (bus_wdata),
        .unlocked_o (unlocked)
    );

    // Hold the load value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                           load_q <= LOAD_INIT;
        else if (wr_ok && bus_addr == A_LOAD) load_q <= bus_wdata;
    end

    // Hold the enable and reset-enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rsten_q <= 1'b0;
        end else if (wr_ok && bus_addr == A_CTRL) begin
            en_q    <= bus_wdata[CTRL_EN_BIT];
            rsten_q <= bus_wdata[CTRL_RST_BIT];
        end
    end

    wdg_down_counter #(.W(DATA_W), .INIT(LOAD_INIT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_q),
        .rst_en_i (rsten_q),
        .reload_i (restart || clr),
        .clr_i    (clr),
        .load_i   (load_q),
        .count_o  (count),
        .irq_o    (irq),
        .fire_o   (fire)
    );

    wdg_rst_pulse #(.CYC(RST_CYCLES)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .pulse_o (wdt_rst_o)
    );

    // Select read data from the live register values.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_LOAD:  bus_rdata = load_q;
            A_COUNT: bus_rdata = count;
            A_CTRL:  bus_rdata = DATA_W'({rsten_q, en_q});
            A_STAT:  bus_rdata = DATA_W'(irq);
            A_LOCK:  bus_rdata = DATA_W'(!unlocked);
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = irq;

    AST_LOCKED_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !unlocked && bus_addr == A_LOAD) |=> $stable(load_q)); // R3
    AST_COUNT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_COUNT && !en_q) |=> $stable(count)); // R10
endmodule

// File: tb/wdg_keyed_timer_bench.sv
module wdg_keyed_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        wdt_rst_o;

    localparam int RC = 4;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rst_hi = 0;
    int irq_seen = 0;
    bit done = 0;
    bit armed = 0;

    // Behavioural reference state.
    logic [31:0] m_load, m_cnt;
    bit m_unl, m_en, m_ren, m_irq, m_fired;
    int m_pl;

    always #2 clk = ~clk;

    wdg_keyed_timer u_wdg_keyed_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .wdt_rst_o(wdt_rst_o)
    );

    function automatic logic [31:0] mread(input logic [11:0] a);
        case (a)
            12'h000: return m_load;
            12'h004: return m_cnt;
            12'h008: return {30'b0, m_ren, m_en};
            12'h014: return {31'b0, m_irq};
            12'hC00: return {31'b0, !m_unl};
            default: return 32'h0;
        endcase
    endfunction

    // Reference model: next state from the values present before the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_unl = 0; m_load = '1; m_cnt = '1; m_en = 0; m_ren = 0;
            m_irq = 0; m_fired = 0; m_pl = 0; armed = 1;
        end else begin
            bit ok, rel, clrw, exp, fire, n_en, n_ren, n_unl;
            logic [31:0] n_load;
            ok    = bus_we && m_unl;
            clrw  = ok && bus_addr == 12'h00C && bus_wdata[0];
            rel   = clrw || (ok && bus_addr == 12'h008 && bus_wdata[0] && !m_en);
            exp   = m_en && m_cnt == 0 && !rel;
            fire  = exp && m_irq && m_ren;
            n_unl = m_unl; n_en = m_en; n_ren = m_ren; n_load = m_load;
            if (bus_we && bus_addr == 12'hC00) n_unl = (bus_wdata == 32'h1ACCE551);
            if (ok && bus_addr == 12'h000) n_load = bus_wdata;
            if (ok && bus_addr == 12'h008) begin n_en = bus_wdata[0]; n_ren = bus_wdata[1]; end
            if (rel) m_cnt = m_load;
            else if (m_en) m_cnt = (m_cnt == 0) ? m_load : m_cnt - 1;
            if (clrw) m_irq = 0; else if (exp) m_irq = 1;
            if (m_pl > 0) m_pl = m_pl - 1;
            if (fire && !m_fired) begin m_pl = RC; m_fired = 1; end
            m_unl = n_unl; m_en = n_en; m_ren = n_ren; m_load = n_load;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare with the model on every clock, away from the edge.
    always begin
        @(negedge clk); #1;
        cycles++;
        if (armed && rst_n) begin
            chk(irq_o == m_irq, "R5 irq_o", {31'b0, irq_o}, {31'b0, m_irq});
            chk(wdt_rst_o == (m_pl > 0), "R7 wdt_rst_o", {31'b0, wdt_rst_o}, {31'b0, m_pl > 0});
            chk(bus_rdata == mread(bus_addr), "R4 bus_rdata", bus_rdata, mread(bus_addr));
            if (wdt_rst_o) rst_hi++;
            if (irq_o) irq_seen++;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_addr = 12'h004;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; bus_we = 0;
        #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        wait (cycles > 60000);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [31:0] frozen;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_chk(12'h004, 32'hFFFF_FFFF, "R1 count");
        rd_chk(12'h000, 32'hFFFF_FFFF, "R1 load");
        rd_chk(12'hC00, 32'h1, "R1 locked");
        rd_chk(12'h008, 32'h0, "R1 ctrl");
        rd_chk(12'h014, 32'h0, "R1 status");
        chk(!irq_o && !wdt_rst_o, "R1 outputs", {30'b0, irq_o, wdt_rst_o}, 0);
        // R3 locked writes discarded
        wr(12'h000, 32'd5);
        wr(12'h008, 32'd1);
        rd_chk(12'h000, 32'hFFFF_FFFF, "R3 load");
        rd_chk(12'h008, 32'h0, "R3 ctrl");
        // R2 unlock
        wr(12'hC00, 32'h1ACCE551);
        rd_chk(12'hC00, 32'h0, "R2 unlocked");
        // R10 full range and read-only count
        wr(12'h004, 32'd7);
        rd_chk(12'h004, 32'hFFFF_FFFF, "R10 count read-only");
        wr(12'h000, 32'hFFFF_FFFF);
        rd_chk(12'h000, 32'hFFFF_FFFF, "R10 load max");
        wr(12'h000, 32'd6);
        // R4 enable and count down
        bus_addr = 12'h008; bus_we = 1; bus_wdata = 32'd1;
        @(negedge clk); bus_we = 0;
        rd_chk(12'h004, 32'd6, "R4 start");
        rd_chk(12'h004, 32'd5, "R4 decrement");
        rd_chk(12'h008, 32'd1, "R4 ctrl readback");
        idle(10);
        rd_chk(12'h014, 32'h1, "R5 status");
        idle(10);
        chk(rst_hi == 0, "R7 no pulse when disabled", rst_hi, 0);
        // R6 clear and reload
        bus_addr = 12'h00C; bus_we = 1; bus_wdata = 32'd1;
        @(negedge clk); bus_we = 0;
        rd_chk(12'h004, 32'd6, "R6 reload");
        rd_chk(12'h014, 32'h0, "R6 cleared");
        // R9 freeze and restart
        wr(12'h008, 32'd0);
        idle(2);
        bus_addr = 12'h004; #1 frozen = bus_rdata;
        idle(4);
        rd_chk(12'h004, frozen, "R9 frozen");
        bus_addr = 12'h008; bus_we = 1; bus_wdata = 32'd1;
        @(negedge clk); bus_we = 0;
        rd_chk(12'h004, 32'd6, "R9 restart");
        // R3 clear ignored while locked
        idle(10);
        wr(12'hC00, 32'h0);
        rd_chk(12'hC00, 32'h1, "R2 relocked");
        wr(12'h00C, 32'd1);
        rd_chk(12'h014, 32'h1, "R3 clear ignored");
        // R7 second expiry fires the pulse
        wr(12'hC00, 32'h1ACCE551);
        wr(12'h00C, 32'd1);
        wr(12'h008, 32'd3);
        idle(30);
        chk(rst_hi == RC, "R7 pulse length", rst_hi, RC);
        idle(40);
        chk(rst_hi == RC, "R8 single shot", rst_hi, RC);
        // R6 periodic service keeps the interrupt away
        wr(12'h00C, 32'd1);
        irq_seen = 0;
        for (int i = 0; i < 60; i++) begin
            if (i % 5 == 0) wr(12'h00C, 32'd1); else idle(1);
        end
        chk(irq_seen == 0, "R6 serviced no irq", irq_seen, 0);
        // clears near expiry: model compares every cycle
        for (int i = 0; i < 40; i++) begin
            if (i % 8 == 0) wr(12'h00C, 32'd1); else idle(1);
        end
        // R8 block reset re-arms the pulse
        rst_n = 0; idle(2); rst_n = 1; @(negedge clk);
        rd_chk(12'hC00, 32'h1, "R1 relocked after reset");
        wr(12'hC00, 32'h1ACCE551);
        wr(12'h000, 32'd2);
        wr(12'h008, 32'd3);
        idle(20);
        chk(rst_hi == 2 * RC, "R8 pulse after reset", rst_hi, 2 * RC);
        finish_run();
    end
endmodule